// File: doc/BRIEF.md
# Cache Line Maintenance Sequencer

This engine turns one region request (a physical address, a virtual address, a byte length and an operation code) into a series of per-line maintenance commands for a virtually indexed, physically tagged first-level cache. Each command carries a line operation, a tag address taken from the physical side and an index address. Before issuing anything it rounds the region out to whole lines. The command stream is paced by an acknowledge input, so a cache that needs several cycles per line simply holds its acknowledge low.

Two ways of passing addresses are chosen at elaboration. In the split scheme the tag and index travel on separate buses and a tag-write strobe marks when the tag register must be loaded. In the packed scheme a single command word carries the line-aligned physical address, with five virtual page-number bits placed in its low bits. Data-cache operations that write back dirty lines also steer the cache's invalidate-mode control and hold completion until the writeback path reports idle.

Top module: `cmaint_seq`

## Requirements
- R1: Request code 1 issues data-cache invalidate line commands (cmd_kind 1), code 2 issues data-cache writeback line commands (cmd_kind 2), code 3 issues data-cache invalidate line commands (cmd_kind 1), and code 4 issues instruction-cache invalidate line commands (cmd_kind 3).
- R2: Unless the fast path of R3 applies, the line count is ceil((len + paddr mod LINE_BYTES) / LINE_BYTES), and both starting addresses are rounded down to a line boundary.
- R3: When len equals PAGE_BYTES and paddr is page aligned, exactly PAGE_BYTES/LINE_BYTES commands are issued from the addresses as given, and in split mode cmd_tag_we is high only on the first command.
- R4: In split mode, command k (from 0) carries cmd_tag = aligned paddr + k*LINE_BYTES and cmd_index = aligned vaddr + k*LINE_BYTES, and outside the fast path cmd_tag_we is high on every command.
- R5: In packed mode, command k carries cmd_index equal to aligned paddr + k*LINE_BYTES with bits [4:0] replaced by bits [PAGE_SHIFT+4:PAGE_SHIFT] of the request's vaddr (bits [17:13] by default), and cmd_tag_we stays low.
- R6: inv_mode_wb is high while the line commands of a code-3 request are issued and while its writeback drain lasts, and low at done and for every other code.
- R7: After its last acknowledged command, a code-2 or code-3 request raises done only once flush_busy has been sampled low; codes 1 and 4 finish regardless of flush_busy.
- R8: After reset req_ready is high and cmd_valid, done and inv_mode_wb are low; a request is taken only while req_ready is high, done is a one-cycle pulse, and req_ready is high again on the cycle after done.
- R9: A zero-length request, or one with code 0, 5, 6 or 7, raises done without issuing any command.
- R10: While cmd_valid is high and cmd_ack is low, cmd_kind, cmd_tag, cmd_index and cmd_tag_we hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 3 | Operation code (1, 2, 3 or 4) |
| req_paddr | input | ADDR_W | Physical start address |
| req_vaddr | input | ADDR_W | Virtual start address |
| req_len | input | LEN_W | Region length in bytes |
| cmd_valid | output | 1 | A line command is presented |
| cmd_ack | input | 1 | Cache consumed the presented command |
| cmd_kind | output | 2 | Line operation: 1 data invalidate, 2 data writeback, 3 instruction invalidate |
| cmd_tag | output | ADDR_W | Physical line address for the tag register |
| cmd_tag_we | output | 1 | Tag register load strobe for this command |
| cmd_index | output | ADDR_W | Index address, or packed command word in packed mode |
| flush_busy | input | 1 | Data-cache writeback still in progress |
| inv_mode_wb | output | 1 | Data-cache invalidate mode set to write back first |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random regions with arbitrary start offsets and short lengths check the rounding rule, since an offset near the end of a line must add one line while an aligned start must not. Page-length requests are run both page aligned and misaligned, which separates the fast path (no adjustment, one tag write) from the general path that rounds and writes a tag every line. Both address schemes run in lockstep on identical stimulus, so a wrong packing shows as a mismatch on the packed word alone. The writeback ops are run with flush_busy held for varying lengths, while the pure invalidate ops are run with it stuck high, which tells a missing drain apart from a drain applied to the wrong codes.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  // request operation codes
  localparam logic [2:0] OPC_DINV   = 3'd1;
  localparam logic [2:0] OPC_DFLUSH = 3'd2;
  localparam logic [2:0] OPC_DFLINV = 3'd3;
  localparam logic [2:0] OPC_IINV   = 3'd4;

  // per-line command kinds
  localparam logic [1:0] LK_NONE   = 2'd0;
  localparam logic [1:0] LK_DINV   = 2'd1;
  localparam logic [1:0] LK_DFLUSH = 2'd2;
  localparam logic [1:0] LK_IINV   = 2'd3;

  // width of the virtual page-number field packed into a command word
  localparam int PACK_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

  function automatic logic op_ok(input logic [2:0] op);
    return (op == OPC_DINV) || (op == OPC_DFLUSH) ||
           (op == OPC_DFLINV) || (op == OPC_IINV);
  endfunction

  // codes with the writeback bit must wait for the flush path to drain
  function automatic logic op_drains(input logic [2:0] op);
    return op_ok(op) && op[1];
  endfunction

  function automatic logic [1:0] op_kind(input logic [2:0] op);
    if (op == OPC_IINV) return LK_IINV;
    if (op[0])          return LK_DINV;
    return LK_DFLUSH;
  endfunction

endpackage

// File: rtl/cmaint_plan.sv
module cmaint_plan
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int CNT_W      = LEN_W + 2 - $clog2(LINE_BYTES)
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] al_paddr,
  output logic [ADDR_W-1:0] al_vaddr,
  output logic [CNT_W-1:0]  lines,
  output logic              full_page,
  output logic              empty
);

  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam int ADJ_W   = LEN_W + 1;
  localparam int RND_W   = ADJ_W + 1;

  logic [ADJ_W-1:0] adj_len;
  logic [RND_W-1:0] rounded;

  assign full_page = (len == LEN_W'(PAGE_BYTES)) && (paddr[PAGE_SH-1:0] == '0);
  assign empty     = (len == '0);

  always_comb begin
    if (full_page) begin
      // page-aligned whole page: already line aligned and line multiple
      al_paddr = paddr;
      al_vaddr = vaddr;
      adj_len  = {1'b0, len};
    end else begin
      al_paddr = {paddr[ADDR_W-1:LINE_SH], {LINE_SH{1'b0}}};
      al_vaddr = {vaddr[ADDR_W-1:LINE_SH], {LINE_SH{1'b0}}};
      adj_len  = {1'b0, len} + ADJ_W'(paddr[LINE_SH-1:0]);
    end
    rounded = {1'b0, adj_len} + RND_W'(LINE_BYTES - 1);
    lines   = CNT_W'(rounded >> LINE_SH);
  end

endmodule

// File: rtl/cmaint_addr.sv
module cmaint_addr
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int LEGACY     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              hold,
  input  logic              first,
  input  logic              full,
  input  logic [ADDR_W-1:0] ld_paddr,
  input  logic [ADDR_W-1:0] ld_vaddr,
  output logic [ADDR_W-1:0] tag,
  output logic [ADDR_W-1:0] index,
  output logic              tag_we
);

  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_INC = ADDR_W'(LINE_BYTES);

  logic [ADDR_W-1:0] paddr_q, paddr_d;

  always_comb begin
    paddr_d = paddr_q;
    if (load)      paddr_d = ld_paddr;
    else if (step) paddr_d = paddr_q + LINE_INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              paddr_q <= '0;
    else if (load || step)   paddr_q <= paddr_d;
  end

  assign tag = paddr_q;

  if (LEGACY != 0) begin : g_packed
    // one command word: physical line address, page-number bits in the low field
    logic [PACK_W-1:0] pack_q, pack_d;

    always_comb begin
      pack_d = pack_q;
      if (load) pack_d = ld_vaddr[PAGE_SH+PACK_W-1:PAGE_SH];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pack_q <= '0;
      else if (load) pack_q <= pack_d;
    end

    assign index  = {paddr_q[ADDR_W-1:PACK_W], pack_q};
    assign tag_we = 1'b0;
  end else begin : g_split
    // separate tag and index; index walks the virtual side
    logic [ADDR_W-1:0] vaddr_q, vaddr_d;

    always_comb begin
      vaddr_d = vaddr_q;
      if (load)      vaddr_d = ld_vaddr;
      else if (step) vaddr_d = vaddr_q + LINE_INC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            vaddr_q <= '0;
      else if (load || step) vaddr_q <= vaddr_d;
    end

    assign index  = vaddr_q;
    assign tag_we = !full || first;
  end

  // R10: presented command stays put until consumed
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(index) && $stable(tag) && $stable(tag_we)));

  // R4: each consumed command moves the physical line forward by one line
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (tag == $past(tag) + LINE_INC));

endmodule

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
  import cmaint_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [CNT_W-1:0] plan_lines,
  input  logic             plan_empty,
  input  logic             plan_full,
  input  logic             cmd_ack,
  input  logic             flush_busy,
  output logic             req_ready,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic             done,
  output logic             inv_mode_wb,
  output logic             load,
  output logic             step,
  output logic             hold,
  output logic             first,
  output logic             full
);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [2:0]       op_q, op_d;
  logic             first_q, first_d;
  logic             full_q, full_d;
  logic             wb_q, wb_d;
  logic             go_lines;
  logic             data_en;

  assign go_lines = req_valid && (st_q == ST_IDLE) && op_ok(req_op) && !plan_empty;
  assign step     = (st_q == ST_ISSUE) && cmd_ack;
  assign data_en  = go_lines || step;

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    op_d    = op_q;
    first_d = first_q;
    full_d  = full_q;
    wb_d    = wb_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (go_lines) begin
            st_d    = ST_ISSUE;
            left_d  = plan_lines;
            op_d    = req_op;
            first_d = 1'b1;
            full_d  = plan_full;
            wb_d    = (req_op == OPC_DFLINV);
          end else begin
            st_d = ST_FIN;
          end
        end
      end
      ST_ISSUE: begin
        if (cmd_ack) begin
          left_d  = left_q - CNT_W'(1);
          first_d = 1'b0;
          if (left_q == CNT_W'(1)) st_d = op_drains(op_q) ? ST_DRAIN : ST_FIN;
        end
      end
      ST_DRAIN: begin
        if (!flush_busy) st_d = ST_FIN;
      end
      default: st_d = ST_IDLE;
    endcase
    // invalidate mode returns to discard-only once the work is finished
    if (st_d == ST_FIN) wb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wb_q <= 1'b0;
    end else begin
      st_q <= st_d;
      wb_q <= wb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      op_q    <= '0;
      first_q <= 1'b0;
      full_q  <= 1'b0;
    end else if (data_en) begin
      left_q  <= left_d;
      op_q    <= op_d;
      first_q <= first_d;
      full_q  <= full_d;
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign cmd_valid   = (st_q == ST_ISSUE);
  assign cmd_kind    = cmd_valid ? op_kind(op_q) : LK_NONE;
  assign done        = (st_q == ST_FIN);
  assign inv_mode_wb = wb_q;
  assign load        = go_lines;
  assign hold        = cmd_valid && !cmd_ack;
  assign first       = first_q;
  assign full        = full_q;

  // R7: no completion while the writeback path is still busy in the drain
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && flush_busy) |=> !done);

  // R8: done lasts one cycle and the engine is open again right after
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R6: write-back invalidate mode covers every command of a code-3 request
  p_wbmode_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op_q == OPC_DFLINV) |-> inv_mode_wb);

  // R6: mode is back to discard-only at completion
  p_wbmode_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !inv_mode_wb);

  // R2: a command is only ever presented with lines still outstanding
  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (left_q != '0));

endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int LEGACY     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_paddr,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              cmd_valid,
  input  logic              cmd_ack,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_tag,
  output logic              cmd_tag_we,
  output logic [ADDR_W-1:0] cmd_index,
  input  logic              flush_busy,
  output logic              inv_mode_wb,
  output logic              done
);

  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int CNT_W   = LEN_W + 2 - LINE_SH;

  logic [ADDR_W-1:0] al_paddr, al_vaddr;
  logic [CNT_W-1:0]  plan_lines;
  logic              plan_full, plan_empty;
  logic              load, step, hold, first, full;

  cmaint_plan #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)
  ) u_plan (
    .paddr     (req_paddr),
    .vaddr     (req_vaddr),
    .len       (req_len),
    .al_paddr  (al_paddr),
    .al_vaddr  (al_vaddr),
    .lines     (plan_lines),
    .full_page (plan_full),
    .empty     (plan_empty)
  );

  cmaint_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .plan_lines  (plan_lines),
    .plan_empty  (plan_empty),
    .plan_full   (plan_full),
    .cmd_ack     (cmd_ack),
    .flush_busy  (flush_busy),
    .req_ready   (req_ready),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .done        (done),
    .inv_mode_wb (inv_mode_wb),
    .load        (load),
    .step        (step),
    .hold        (hold),
    .first       (first),
    .full        (full)
  );

  cmaint_addr #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .LEGACY(LEGACY)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .hold     (hold),
    .first    (first),
    .full     (full),
    .ld_paddr (al_paddr),
    .ld_vaddr (al_vaddr),
    .tag      (cmd_tag),
    .index    (cmd_index),
    .tag_we   (cmd_tag_we)
  );

  // R1: a presented command always names a real line operation
  p_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind != LK_NONE));

  // R8: a request is never taken while commands are outstanding
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(step && done)) |-> !req_ready);

endmodule

// File: tb/sim_cmaint_seq.sv
module sim_cmaint_seq;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int LB = 32;
  localparam int PB = 8192;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_paddr, req_vaddr;
  logic [LW-1:0] req_len;
  logic          cmd_ack, flush_busy;

  logic          a_ready, a_valid, a_tag_we, a_wb, a_done;
  logic [1:0]    a_kind;
  logic [AW-1:0] a_tag, a_index;
  logic          b_ready, b_valid, b_tag_we, b_wb, b_done;
  logic [1:0]    b_kind;
  logic [AW-1:0] b_tag, b_index;

  cmaint_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_ready),
    .req_op(req_op), .req_paddr(req_paddr), .req_vaddr(req_vaddr), .req_len(req_len),
    .cmd_valid(a_valid), .cmd_ack(cmd_ack), .cmd_kind(a_kind), .cmd_tag(a_tag),
    .cmd_tag_we(a_tag_we), .cmd_index(a_index), .flush_busy(flush_busy),
    .inv_mode_wb(a_wb), .done(a_done)
  );

  cmaint_seq #(.LEGACY(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_ready),
    .req_op(req_op), .req_paddr(req_paddr), .req_vaddr(req_vaddr), .req_len(req_len),
    .cmd_valid(b_valid), .cmd_ack(cmd_ack), .cmd_kind(b_kind), .cmd_tag(b_tag),
    .cmd_tag_we(b_tag_we), .cmd_index(b_index), .flush_busy(flush_busy),
    .inv_mode_wb(b_wb), .done(b_done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_kind(input logic [2:0] op);
    if (op == 3'd4) return 2'd3;
    if (op[0])      return 2'd1;
    return 2'd2;
  endfunction

  task automatic run_req(input logic [AW-1:0] pa, input logic [AW-1:0] va,
                         input int len, input logic [2:0] op, input int extra);
    bit full, legal, waits, prev_hold, ack, fin;
    logic [AW-1:0] ap, av, e_tag, e_idx, e_pk, hold_idx, hold_tag;
    int nl, adj, k, cyc, after;
    legal = (op >= 3'd1) && (op <= 3'd4);
    full  = (len == PB) && (pa[12:0] == 13'd0);
    if (full) begin
      ap = pa; av = va; nl = PB / LB;
    end else begin
      adj = len + int'(pa[4:0]);
      ap  = {pa[AW-1:5], 5'd0};
      av  = {va[AW-1:5], 5'd0};
      nl  = (adj + LB - 1) / LB;
    end
    if (!legal || len == 0) nl = 0;
    waits = legal && op[1] && (nl > 0);

    @(negedge clk);
    chk(a_ready == 1'b1, "R8", "ready before request", 64'(a_ready), 64'd1);
    req_paddr = pa; req_vaddr = va; req_len = LW'(len); req_op = op;
    req_valid = 1'b1; flush_busy = 1'b1; cmd_ack = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; cyc = 0; after = 0; prev_hold = 1'b0; fin = 1'b0;
    while (!fin) begin
      if (a_done) begin
        fin = 1'b1;
        if (waits) chk(flush_busy == 1'b0, "R7", "done while writeback busy", 64'(flush_busy), 64'd0);
        else if (nl > 0) chk(a_done, "R7", "invalidate ignores busy", 64'(a_done), 64'd1);
        chk(b_done == 1'b1, "R5", "packed variant done in step", 64'(b_done), 64'd1);
        chk(a_wb == 1'b0, "R6", "mode at done", 64'(a_wb), 64'd0);
      end else begin
        if (a_valid) begin
          if (prev_hold) begin
            chk(a_index == hold_idx, "R10", "index held", 64'(a_index), 64'(hold_idx));
            chk(a_tag == hold_tag, "R10", "tag held", 64'(a_tag), 64'(hold_tag));
          end
          chk(a_wb == (op == 3'd3), "R6", "mode during lines", 64'(a_wb), 64'(op == 3'd3));
          ack = ($urandom % 3) != 0;
          if (ack) begin
            if (k >= nl) begin
              chk(1'b0, "R2", "extra command", 64'(k), 64'(nl));
            end else begin
              e_tag = ap + AW'(k * LB);
              e_idx = av + AW'(k * LB);
              e_pk  = {e_tag[AW-1:5], va[17:13]};
              chk(a_kind == exp_kind(op), "R1", "kind", 64'(a_kind), 64'(exp_kind(op)));
              chk(a_tag == e_tag, "R4", "tag", 64'(a_tag), 64'(e_tag));
              chk(a_index == e_idx, "R4", "index", 64'(a_index), 64'(e_idx));
              if (full)
                chk(a_tag_we == (k == 0), "R3", "single tag write", 64'(a_tag_we), 64'(k == 0));
              else
                chk(a_tag_we == 1'b1, "R4", "tag write each line", 64'(a_tag_we), 64'd1);
              chk(b_valid && b_index == e_pk, "R5", "packed word", 64'(b_index), 64'(e_pk));
              chk(b_tag_we == 1'b0, "R5", "packed tag strobe", 64'(b_tag_we), 64'd0);
            end
            k++;
            prev_hold = 1'b0;
          end else begin
            prev_hold = 1'b1;
            hold_idx  = a_index;
            hold_tag  = a_tag;
          end
          cmd_ack = ack;
        end else begin
          cmd_ack = 1'b0;
          prev_hold = 1'b0;
        end
        if (waits && k == nl) begin
          after++;
          if (after > extra) flush_busy = 1'b0;
        end
        @(negedge clk);
        cyc++;
        if (cyc > 20000) begin
          chk(1'b0, "R8", "request never completed", 64'(k), 64'(nl));
          fin = 1'b1;
        end
      end
    end
    chk(k == nl, (nl == 0) ? "R9" : "R2", "line count", 64'(k), 64'(nl));
    cmd_ack = 1'b0;
    flush_busy = 1'b0;
    @(negedge clk);
    chk(!a_done && a_ready, "R8", "done single cycle then ready", 64'({a_done, a_ready}), 64'b01);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd2024);
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_paddr = '0; req_vaddr = '0;
    req_len = '0; cmd_ack = 1'b0; flush_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(a_ready && !a_valid && !a_done && !a_wb, "R8", "reset state",
        64'({a_ready, a_valid, a_done, a_wb}), 64'b1000);

    // directed corners
    run_req(32'h0000_1000, 32'h0002_3000, 0, 3'd3, 2);          // R9 zero length
    run_req(32'h0000_1000, 32'h0002_3000, 64, 3'd0, 0);         // R9 code 0
    run_req(32'h0000_1000, 32'h0002_3000, 64, 3'd6, 0);         // R9 code 6
    run_req(32'h0000_101F, 32'h0004_E01F, 1, 3'd1, 0);          // R2 one byte, one line
    run_req(32'h0000_101F, 32'h0004_E01F, 2, 3'd2, 3);          // R2 spans two lines
    run_req(32'h0000_2040, 32'h0003_6040, 32, 3'd4, 0);         // R1 aligned single line
    run_req(32'h0001_4000, 32'h0005_C000, PB, 3'd3, 5);         // R3 fast path
    run_req(32'h0001_4020, 32'h0005_C020, PB, 3'd2, 1);         // R2 page length, not aligned
    run_req(32'h0000_0008, 32'h0003_E008, 100, 3'd1, 0);        // R7 invalidate with busy high
    run_req(32'h0000_0008, 32'h0003_E008, 100, 3'd4, 0);        // R7 icache with busy high

    // random regions
    for (int i = 0; i < 80; i++) begin
      logic [2:0] rop;
      rop = 3'(1 + ($urandom % 4));
      if (($urandom % 10) == 0) rop = 3'(5 + ($urandom % 3));
      run_req($urandom, $urandom, int'($urandom % 300), rop, int'($urandom % 4));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule